// File: doc/BRIEF.md
# Address-Pattern Memory Bank Selector

This block picks one of sixteen memory banks, or none, without any register write. Software enters a covert sequence of sixteen consecutive read cycles. On each read the block samples a four-bit nibble from four address lines. The sequence must match a pattern held in a parameter. The last five steps of that sequence carry an enable bit and a four-bit bank number on the least significant address line. When the whole sequence matches, the new selection is latched onto four bank-select outputs. The change takes effect as the read that carried the final step ends.

The chip-enable input is active low and asynchronous to the system clock. It is synchronised inside the block, and its falling and rising edges are detected there. The address nibble is captured on the detected falling edge. While a bank is enabled, the active-low chip-enable output follows the chip-enable input through gates only. A power-fail input blocks captures and forces the chip-enable output inactive.

Control and data here are plain level pins. No stream of data enters or leaves the block, so no valid/ready handshake is used and no back-pressure exists.

Top module: `bank_seq_selector`

## Requirements
- R1: After reset, `bank_sel` is 0 and `ce_out_n` is 1 whatever `ce_in_n` does, until a valid enabling sequence commits.
- R2: Each falling edge of `ce_in_n` captures one nibble from `addr_nib`. Bit 0 is line W, bit 1 is X, bit 2 is Y and bit 3 is Z.
- R3: A captured nibble of 4'hF restarts the sequence, so the next capture is compared as step 0. This holds in any state of the sequence.
- R4: Step k is compared with `PATTERN[4k+3:4k]`, whose default is 64'hAA444A5A55AAA5A5. All four bits are compared for steps 0 to 10. Only bits 3:1 are compared for steps 11 to 15.
- R5: Bit 0 of step 11 is the enable bit. Bit 0 of steps 12, 13, 14 and 15 becomes `bank_sel[3]`, `[2]`, `[1]` and `[0]` respectively.
- R6: A fully matched sequence whose enable bit is 0 sets `bank_sel` to 0 and leaves `ce_out_n` at 1 whatever `ce_in_n` does.
- R7: A new selection takes effect only on the rising edge of `ce_in_n` that ends step 15. Until that edge, `bank_sel` keeps its old value.
- R8: While a bank is enabled and `pwr_fail` is low, `ce_out_n` equals `ce_in_n` with no clock delay.
- R9: `bank_sel` changes only when a complete matching sequence commits. Reads done as ordinary memory cycles leave it unchanged.
- R10: A capture that mismatches a compared bit aborts the sequence, and the current selection is kept. The next capture is compared as step 1 if the mismatching nibble equals the step 0 pattern, and as step 0 otherwise.
- R11: While `pwr_fail` is 1, `ce_out_n` is 1 and captures are ignored. A partly entered sequence is discarded and the latched selection is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_nib | input | 4 | Address lines {Z,Y,X,W} sampled per read |
| ce_in_n | input | 1 | Active-low chip-enable input, asynchronous |
| pwr_fail | input | 1 | High while supply is failing |
| bank_sel | output | 4 | Latched bank number, bit 0 is the lowest select line |
| ce_out_n | output | 1 | Gated active-low chip-enable output |

## Verification
Some rules are checked by assertions on every clock. A 4'hF capture returns the step counter to 0. A mismatch leaves the counter at step 0 or step 1. A power-fail cycle clears the sequence and any pending commit. A pending commit arises only from step 15. The selection never moves without a commit, and a disabled selection always drives zeros.

Other behaviour can only be shown by the bench's scenarios:
- the correct bank value for each of the sixteen banks;
- the exact mapping of step bits onto select lines;
- the commit waiting for the rising edge;
- the gated chip-enable output following its input;
- recovery through 4'hF;
- the step 1 fallback when a mismatching nibble looks like step 0.

// File: rtl/bank_sel_pkg.sv
package bank_sel_pkg;
  localparam int ADDR_W = 4;
  localparam int BANK_W = 4;
  localparam logic [63:0] DEFAULT_PATTERN = 64'hAA444A5A55AAA5A5;

  typedef logic [ADDR_W-1:0] nib_t;

  typedef struct packed {
    logic              en;
    logic [BANK_W-1:0] bank;
  } sel_t;
endpackage

// File: rtl/ce_edge_sync.sv
module ce_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ce_in_n,
  output logic fall,
  output logic rise
);
  logic [STAGES:0] sh_q;
  logic synced, prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '1;
    else        sh_q <= {sh_q[STAGES-1:0], ce_in_n};
  end

  assign synced = sh_q[STAGES-1];
  assign prev   = sh_q[STAGES];
  assign fall   = prev & ~synced;
  assign rise   = ~prev & synced;
endmodule

// File: rtl/seq_matcher.sv
module seq_matcher
  import bank_sel_pkg::*;
#(
  parameter int STEPS = 16,
  parameter logic [STEPS*ADDR_W-1:0] PATTERN = DEFAULT_PATTERN
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fall,
  input  logic rise,
  input  logic pwr_fail,
  input  nib_t nib,
  output logic commit,
  output sel_t new_sel
);
  localparam int STEP_W  = $clog2(STEPS);
  localparam int EN_STEP = STEPS - BANK_W - 1;

  logic [STEP_W-1:0] step_q;
  logic              pend_q;
  logic              pend_en_q;
  logic [BANK_W-1:0] pend_bank_q;
  nib_t              exp_nib, cmp_mask;
  logic              cap, is_restart, hit, first_hit, advance;

  assign exp_nib    = PATTERN[int'(step_q)*ADDR_W +: ADDR_W];
  assign cmp_mask   = (int'(step_q) < EN_STEP) ? '1 : {{(ADDR_W-1){1'b1}}, 1'b0};
  assign hit        = ((nib ^ exp_nib) & cmp_mask) == '0;
  assign is_restart = &nib;
  assign first_hit  = nib == PATTERN[ADDR_W-1:0];
  assign cap        = fall & ~pwr_fail;
  assign advance    = cap & ~is_restart & hit;
  assign commit     = rise & pend_q & ~pwr_fail;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q <= '0;
      pend_q <= 1'b0;
    end else if (pwr_fail) begin
      step_q <= '0;
      pend_q <= 1'b0;
    end else begin
      if (rise) pend_q <= 1'b0;
      if (cap) begin
        if (is_restart) begin
          step_q <= '0;
        end else if (hit) begin
          if (int'(step_q) == STEPS-1) begin
            step_q <= '0;
            pend_q <= 1'b1;
          end else begin
            step_q <= step_q + 1'b1;
          end
        end else begin
          step_q <= first_hit ? STEP_W'(1) : '0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                           pend_en_q <= 1'b0;
    else if (advance && int'(step_q) == EN_STEP)          pend_en_q <= nib[0];
  end

  for (genvar b = 0; b < BANK_W; b++) begin : g_bank
    localparam int LOAD_STEP = STEPS - 1 - b;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                         pend_bank_q[b] <= 1'b0;
      else if (advance && int'(step_q) == LOAD_STEP)      pend_bank_q[b] <= nib[0];
    end
  end

  assign new_sel.en   = pend_en_q;
  assign new_sel.bank = pend_bank_q;

  p_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cap && is_restart) |=> (step_q == '0));

  p_abort_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cap && !is_restart && !hit) |=> (int'(step_q) <= 1));

  p_pf_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_fail |=> (step_q == '0 && !pend_q));

  p_pend_from_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_q) |-> (int'($past(step_q)) == STEPS-1));
endmodule

// File: rtl/bank_latch.sv
module bank_latch
  import bank_sel_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit,
  input  sel_t              new_sel,
  input  logic              ce_in_n,
  input  logic              pwr_fail,
  output logic [BANK_W-1:0] bank_sel,
  output logic              ce_out_n
);
  sel_t cur_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q <= '0;
    end else if (commit) begin
      cur_q.en   <= new_sel.en;
      cur_q.bank <= new_sel.en ? new_sel.bank : '0;
    end
  end

  assign bank_sel = cur_q.bank;
  assign ce_out_n = ce_in_n | ~cur_q.en | pwr_fail;

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(bank_sel));

  p_off_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !cur_q.en |-> (bank_sel == '0 && ce_out_n));
endmodule

// File: rtl/bank_seq_selector.sv
module bank_seq_selector
  import bank_sel_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int STEPS = 16,
  parameter logic [STEPS*ADDR_W-1:0] PATTERN = DEFAULT_PATTERN
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_nib,
  input  logic              ce_in_n,
  input  logic              pwr_fail,
  output logic [BANK_W-1:0] bank_sel,
  output logic              ce_out_n
);
  logic fall, rise, commit;
  sel_t new_sel;

  ce_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .ce_in_n(ce_in_n), .fall(fall), .rise(rise)
  );

  seq_matcher #(.STEPS(STEPS), .PATTERN(PATTERN)) u_match (
    .clk(clk), .rst_n(rst_n), .fall(fall), .rise(rise), .pwr_fail(pwr_fail),
    .nib(addr_nib), .commit(commit), .new_sel(new_sel)
  );

  bank_latch u_latch (
    .clk(clk), .rst_n(rst_n), .commit(commit), .new_sel(new_sel),
    .ce_in_n(ce_in_n), .pwr_fail(pwr_fail), .bank_sel(bank_sel), .ce_out_n(ce_out_n)
  );
endmodule

// File: tb/bank_seq_selector_tb.sv
module bank_seq_selector_tb;
  localparam logic [63:0] PAT = 64'hAA444A5A55AAA5A5;

  logic       clk = 0;
  logic       rst_n = 0;
  logic [3:0] addr_nib = 4'h0;
  logic       ce_in_n = 1;
  logic       pwr_fail = 0;
  logic [3:0] bank_sel;
  logic       ce_out_n;

  int checks = 0;
  int fails  = 0;
  logic       m_en = 0;
  logic [3:0] m_bank = 0;

  always #10 clk = ~clk;

  bank_seq_selector u_dut (
    .clk(clk), .rst_n(rst_n), .addr_nib(addr_nib), .ce_in_n(ce_in_n),
    .pwr_fail(pwr_fail), .bank_sel(bank_sel), .ce_out_n(ce_out_n)
  );

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] step_nib(input int k, input logic en, input logic [3:0] bank);
    logic [3:0] p;
    p = PAT[k*4 +: 4];
    if (k < 11)       return p;
    else if (k == 11) return {p[3:1], en};
    else              return {p[3:1], bank[15-k]};
  endfunction

  function automatic logic [3:0] exp_sel();
    return m_en ? m_bank : 4'h0;
  endfunction

  // one read cycle; checks gated chip-enable output while low (R8, R1, R6, R11)
  task automatic read_cycle(input logic [3:0] n, input bit last);
    addr_nib = n;
    @(negedge clk);
    ce_in_n = 0;
    #1;
    chk(ce_out_n == ((m_en && !pwr_fail) ? 1'b0 : 1'b1), "R8 ce_out follows", ce_out_n,
        (m_en && !pwr_fail) ? 0 : 1);
    repeat (6) @(negedge clk);
    if (last) chk(bank_sel == exp_sel(), "R7 no change before rise", bank_sel, exp_sel());
    ce_in_n = 1;
    repeat (6) @(negedge clk);
  endtask

  task automatic enter_seq(input logic en, input logic [3:0] bank);
    read_cycle(4'hF, 0);
    for (int k = 0; k < 16; k++) read_cycle(step_nib(k, en, bank), k == 15);
    m_en = en;
    m_bank = bank;
  endtask

  task automatic check_sel(input string tag);
    chk(bank_sel == exp_sel(), tag, bank_sel, exp_sel());
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog act=0 exp=1");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd7321);
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(bank_sel == 4'h0, "R1 reset bank_sel", bank_sel, 0);
    chk(ce_out_n == 1'b1, "R1 reset ce_out_n", ce_out_n, 1);
    rst_n = 1;
    repeat (2) @(negedge clk);
    ce_in_n = 0; #1;
    chk(ce_out_n == 1'b1, "R1 ce_out_n high after reset", ce_out_n, 1);
    ce_in_n = 1;
    repeat (8) @(negedge clk);

    // R4 R5 R2: every bank
    for (int b = 0; b < 16; b++) begin
      enter_seq(1'b1, 4'(b));
      check_sel("R5 bank select mapping");
    end

    // R9: ordinary reads do not disturb selection
    for (int i = 0; i < 8; i++) read_cycle(4'($urandom_range(0, 14)), 0);
    check_sel("R9 hold across memory reads");

    // R6 banks off
    enter_seq(1'b0, 4'hB);
    check_sel("R6 banks off bank_sel");
    ce_in_n = 0; #1;
    chk(ce_out_n == 1'b1, "R6 ce_out_n stays high", ce_out_n, 1);
    ce_in_n = 1;
    repeat (8) @(negedge clk);

    // R10 mismatch at each step
    enter_seq(1'b1, 4'h6);
    for (int k = 0; k < 16; k++) begin
      read_cycle(4'hF, 0);
      for (int j = 0; j < k; j++) read_cycle(step_nib(j, 1'b1, 4'h9), 0);
      read_cycle(step_nib(k, 1'b1, 4'h9) ^ 4'b0010, 0);
      for (int j = k + 1; j < 16; j++) read_cycle(step_nib(j, 1'b1, 4'h9), j == 15);
      check_sel("R10 mismatch keeps selection");
    end

    // R10 step-1 fallback: step 3 receives step-0 nibble
    read_cycle(4'hF, 0);
    for (int j = 0; j < 3; j++) read_cycle(step_nib(j, 1'b1, 4'hD), 0);
    read_cycle(step_nib(0, 1'b1, 4'hD), 0);
    for (int j = 1; j < 16; j++) read_cycle(step_nib(j, 1'b1, 4'hD), j == 15);
    m_en = 1; m_bank = 4'hD;
    check_sel("R10 fallback to step 1");

    // R3 restart mid-sequence
    for (int j = 0; j < 7; j++) read_cycle(step_nib(j, 1'b1, 4'h2), 0);
    enter_seq(1'b1, 4'h2);
    check_sel("R3 restart via F");

    // R11 power fail
    read_cycle(4'hF, 0);
    for (int j = 0; j < 8; j++) read_cycle(step_nib(j, 1'b1, 4'h5), 0);
    pwr_fail = 1;
    read_cycle(step_nib(8, 1'b1, 4'h5), 0);
    chk(ce_out_n == 1'b1, "R11 ce_out_n forced high", ce_out_n, 1);
    pwr_fail = 0;
    for (int j = 9; j < 16; j++) read_cycle(step_nib(j, 1'b1, 4'h5), j == 15);
    check_sel("R11 sequence dropped, bank kept");

    // random mix
    for (int i = 0; i < 20; i++) begin
      logic en;
      logic [3:0] b;
      en = ($urandom_range(0, 3) != 0);
      b = 4'($urandom_range(0, 15));
      if ($urandom_range(0, 1) == 1) read_cycle(4'($urandom_range(0, 14)), 0);
      enter_seq(en, b);
      check_sel("R5 random entry");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule